// File: doc/BRIEF.md
# Stereo Sample FIFO Pair with Interrupt Logic

This block holds the sample buffering for one stereo audio channel. A host writes left/right sample pairs into a transmit FIFO through a small word-addressed register port. The serial side drains these pairs through a valid/ready stream. In the other direction, the serial side pushes received pairs through a valid-only stream, and the host reads them out of the receive FIFO through the same register port.

Each FIFO has a programmable trigger level and a flush command. Each FIFO also has a sticky overrun flag, which is cleared by reading a dedicated clear address. Four status conditions feed the interrupt output: transmit low, receive data available, transmit overrun and receive overrun. A mask register gates each of these conditions.

The transmit stream follows the usual valid/ready rules:
- `tx_valid` is high whenever the transmit FIFO holds at least one pair.
- A pair leaves the FIFO on each clock edge where `tx_valid` and `tx_ready` are both high.
- The presented pair stays stable until it is taken.

The receive stream has no back-pressure. A pair offered with `rx_valid` while the receive FIFO is full is lost, and the loss is recorded as a receive overrun.

The FIFO depth is 2^(1+`FIFO_CFG`) pairs. After reset, both trigger registers hold half the depth minus one.

Top module: `audio_chan_fifo`

## Requirements
- R1: The register map uses word addresses, and every read returns data combinationally in the same cycle as `reg_rd`. The addresses are:
  - 0: left sample. A write stages the transmit left sample; a read returns the left half of the receive head.
  - 1: right sample. A write pushes the transmit pair; a read returns the right half of the receive head and pops it.
  - 2: transmit trigger.
  - 3: receive trigger.
  - 4: status.
  - 5: mask.
  - 6: transmit flush.
  - 7: receive flush.
  - 8: transmit overrun clear.
  - 9: receive overrun clear.
  After reset the mask reads 0x33 and each trigger reads DEPTH/2-1.
- R2: A write to address 1 pushes the pair {last value written to address 0, `reg_wdata`}. The transmit stream presents pairs in the order they were pushed. `tx_valid` is low while the transmit FIFO is empty.
- R3: Each accepted `rx_valid` beat is stored as one pair. The host reads the pairs back in arrival order: the left half first at address 0, which does not pop, and then the right half at address 1, which pops.
- R4: Status bit 4 (transmit low) is 1 while the transmit level is less than or equal to the transmit trigger register. The trigger register holds the desired threshold minus one.
- R5: Status bit 0 (receive available) is 1 while the receive level is greater than or equal to the receive trigger register plus one.
- R6: A push to address 1 while the transmit FIFO is full is dropped, and status bit 5 (transmit overrun) is set. The stored pairs are unchanged. Fullness is judged at the start of the cycle, even if a pop happens in the same cycle.
- R7: A receive beat that arrives while the receive FIFO is full is dropped, and status bit 1 (receive overrun) is set.
- R8: Reading address 8 returns the transmit overrun flag in bit 0 and then clears that flag. Reading address 9 does the same for the receive overrun flag. Each clear leaves the other flag untouched. A new overrun in the same cycle as its clear wins over the clear.
- R9: Writing address 6 or address 7 with bit 0 set empties that FIFO. A write with bit 0 clear has no effect. A flush does not clear the overrun flags. A receive beat that arrives in the same cycle as a receive flush is discarded without setting an overrun.
- R10: Mask bits 0, 1, 4 and 5 mask the status bit at the same position; a bit value of 1 masks that condition. `irq` is high exactly when at least one status bit is 1 and its mask bit is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_addr | input | 4 | Register word address |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | BUS_W | Register write data |
| reg_rd | input | 1 | Register read strobe (side effects at clock edge) |
| reg_rdata | output | BUS_W | Read data for reg_addr |
| tx_valid | output | 1 | Transmit pair available |
| tx_ready | input | 1 | Serial side takes the transmit pair |
| tx_left | output | SAMPLE_W | Transmit head left sample |
| tx_right | output | SAMPLE_W | Transmit head right sample |
| rx_valid | input | 1 | Received pair offered (no back-pressure) |
| rx_left | input | SAMPLE_W | Received left sample |
| rx_right | input | SAMPLE_W | Received right sample |
| irq | output | 1 | Interrupt request |

## Verification
The bench sweeps every trigger value for both FIFOs across every fill level from empty to full. This exposes an off-by-one in the minus-one trigger encoding, which would move the transmit-low or receive-available edge by one level. Each sweep ends with one push into a full FIFO, so a design that stored the dropped pair, or wrapped its pointer over the oldest data, shows a corrupted drain order.

The bench then sets the overrun flags together and clears them one at a time. A design that shared a clear between the two flags, or that cleared a flag on flush, is caught here.

Finally, the bench walks all sixteen mask patterns against a fully set status word. This catches a swapped bit pair or an inverted mask sense.

// File: rtl/acf_pkg.sv
package acf_pkg;

  localparam int ADDR_W = 4;

  typedef enum logic [ADDR_W-1:0] {
    A_SMP_L    = 4'd0,
    A_SMP_R    = 4'd1,
    A_TX_TRIG  = 4'd2,
    A_RX_TRIG  = 4'd3,
    A_STATUS   = 4'd4,
    A_MASK     = 4'd5,
    A_TX_FLUSH = 4'd6,
    A_RX_FLUSH = 4'd7,
    A_TX_OVCLR = 4'd8,
    A_RX_OVCLR = 4'd9
  } acf_addr_e;

  // Status and mask bit positions (shared layout)
  localparam int BIT_RX_AVAIL = 0;
  localparam int BIT_RX_OVR   = 1;
  localparam int BIT_TX_LOW   = 4;
  localparam int BIT_TX_OVR   = 5;

  localparam logic [7:0] MASK_USED  = 8'h33;
  localparam logic [7:0] MASK_RESET = 8'h33;

endpackage

// File: rtl/acf_fifo.sv
module acf_fifo #(
  parameter int W          = 32,
  parameter int DEPTH_LOG2 = 3,
  localparam int DEPTH     = 1 << DEPTH_LOG2,
  localparam int LVL_W     = DEPTH_LOG2 + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic             push,
  input  logic [W-1:0]     push_data,
  input  logic             pop,
  output logic [W-1:0]     head,
  output logic [LVL_W-1:0] level,
  output logic             empty,
  output logic             drop
);

  logic [W-1:0]            mem [DEPTH];
  logic [DEPTH_LOG2-1:0]   wr_ptr, rd_ptr;
  logic [LVL_W-1:0]        count;
  logic                    full, do_push, do_pop;

  localparam logic [LVL_W-1:0] FULL_LVL = LVL_W'(DEPTH);

  assign full    = (count == FULL_LVL);
  assign empty   = (count == '0);
  assign do_push = push && !full && !flush;
  assign do_pop  = pop && !empty && !flush;
  assign drop    = push && full && !flush;
  assign head    = mem[rd_ptr];
  assign level   = count;

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || flush) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (do_push) wr_ptr <= wr_ptr + 1'b1;
      if (do_pop)  rd_ptr <= rd_ptr + 1'b1;
      case ({do_push, do_pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

endmodule

// File: rtl/acf_irq_ctrl.sv
module acf_irq_ctrl
  import acf_pkg::*;
#(
  parameter int TRIG_W = 3,
  localparam int LVL_W = TRIG_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [LVL_W-1:0]  tx_level,
  input  logic [LVL_W-1:0]  rx_level,
  input  logic [TRIG_W-1:0] tx_trig,
  input  logic [TRIG_W-1:0] rx_trig,
  input  logic              tx_drop,
  input  logic              rx_drop,
  input  logic              tx_ovr_clr,
  input  logic              rx_ovr_clr,
  input  logic              mask_we,
  input  logic [7:0]        mask_wdata,
  output logic [7:0]        status,
  output logic [7:0]        mask,
  output logic              irq
);

  logic tx_ovr, rx_ovr;
  logic tx_low, rx_avail;
  logic [LVL_W-1:0] rx_need;

  assign rx_need  = {1'b0, rx_trig} + 1'b1;
  assign tx_low   = (tx_level <= {1'b0, tx_trig});
  assign rx_avail = (rx_level >= rx_need);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tx_ovr <= 1'b0;
      rx_ovr <= 1'b0;
      mask   <= MASK_RESET;
    end else begin
      if (tx_drop)         tx_ovr <= 1'b1;
      else if (tx_ovr_clr) tx_ovr <= 1'b0;
      if (rx_drop)         rx_ovr <= 1'b1;
      else if (rx_ovr_clr) rx_ovr <= 1'b0;
      if (mask_we)         mask   <= mask_wdata & MASK_USED;
    end
  end

  always_comb begin
    status               = '0;
    status[BIT_RX_AVAIL] = rx_avail;
    status[BIT_RX_OVR]   = rx_ovr;
    status[BIT_TX_LOW]   = tx_low;
    status[BIT_TX_OVR]   = tx_ovr;
  end

  assign irq = |(status & ~mask & MASK_USED);

endmodule

// File: rtl/audio_chan_fifo.sv
module audio_chan_fifo
  import acf_pkg::*;
#(
  parameter int SAMPLE_W = 16,
  parameter int BUS_W    = 32,
  parameter int FIFO_CFG = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [ADDR_W-1:0]   reg_addr,
  input  logic                reg_wr,
  input  logic [BUS_W-1:0]    reg_wdata,
  input  logic                reg_rd,
  output logic [BUS_W-1:0]    reg_rdata,
  output logic                tx_valid,
  input  logic                tx_ready,
  output logic [SAMPLE_W-1:0] tx_left,
  output logic [SAMPLE_W-1:0] tx_right,
  input  logic                rx_valid,
  input  logic [SAMPLE_W-1:0] rx_left,
  input  logic [SAMPLE_W-1:0] rx_right,
  output logic                irq
);

  localparam int DEPTH_LOG2 = FIFO_CFG + 1;
  localparam int DEPTH      = 1 << DEPTH_LOG2;
  localparam int TRIG_W     = DEPTH_LOG2;
  localparam int LVL_W      = DEPTH_LOG2 + 1;
  localparam int PAIR_W     = 2 * SAMPLE_W;
  localparam logic [TRIG_W-1:0] TRIG_RESET = TRIG_W'(DEPTH / 2 - 1);

  // Register decode
  logic wr_left, tx_push, rx_pop;
  logic tx_flush, rx_flush, tx_ovr_clr, rx_ovr_clr, mask_we;
  logic tx_trig_we, rx_trig_we;

  assign wr_left    = reg_wr && (reg_addr == A_SMP_L);
  assign tx_push    = reg_wr && (reg_addr == A_SMP_R);
  assign rx_pop     = reg_rd && (reg_addr == A_SMP_R);
  assign tx_trig_we = reg_wr && (reg_addr == A_TX_TRIG);
  assign rx_trig_we = reg_wr && (reg_addr == A_RX_TRIG);
  assign mask_we    = reg_wr && (reg_addr == A_MASK);
  assign tx_flush   = reg_wr && (reg_addr == A_TX_FLUSH) && reg_wdata[0];
  assign rx_flush   = reg_wr && (reg_addr == A_RX_FLUSH) && reg_wdata[0];
  assign tx_ovr_clr = reg_rd && (reg_addr == A_TX_OVCLR);
  assign rx_ovr_clr = reg_rd && (reg_addr == A_RX_OVCLR);

  // Staged left sample and trigger registers
  logic [SAMPLE_W-1:0] left_hold;
  logic [TRIG_W-1:0]   tx_trig, rx_trig;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      left_hold <= '0;
      tx_trig   <= TRIG_RESET;
      rx_trig   <= TRIG_RESET;
    end else begin
      if (wr_left)    left_hold <= reg_wdata[SAMPLE_W-1:0];
      if (tx_trig_we) tx_trig   <= reg_wdata[TRIG_W-1:0];
      if (rx_trig_we) rx_trig   <= reg_wdata[TRIG_W-1:0];
    end
  end

  // Transmit FIFO
  logic [PAIR_W-1:0] tx_head;
  logic [LVL_W-1:0]  tx_level;
  logic              tx_empty, tx_drop;

  acf_fifo #(.W(PAIR_W), .DEPTH_LOG2(DEPTH_LOG2)) u_tx_fifo (
    .clk       (clk),
    .rst_n     (rst_n),
    .flush     (tx_flush),
    .push      (tx_push),
    .push_data ({left_hold, reg_wdata[SAMPLE_W-1:0]}),
    .pop       (tx_ready),
    .head      (tx_head),
    .level     (tx_level),
    .empty     (tx_empty),
    .drop      (tx_drop)
  );

  assign tx_valid = !tx_empty;
  assign tx_left  = tx_head[PAIR_W-1:SAMPLE_W];
  assign tx_right = tx_head[SAMPLE_W-1:0];

  // Receive FIFO
  logic [PAIR_W-1:0] rx_head;
  logic [LVL_W-1:0]  rx_level;
  logic              rx_empty, rx_drop;

  acf_fifo #(.W(PAIR_W), .DEPTH_LOG2(DEPTH_LOG2)) u_rx_fifo (
    .clk       (clk),
    .rst_n     (rst_n),
    .flush     (rx_flush),
    .push      (rx_valid),
    .push_data ({rx_left, rx_right}),
    .pop       (rx_pop),
    .head      (rx_head),
    .level     (rx_level),
    .empty     (rx_empty),
    .drop      (rx_drop)
  );

  // Status, mask and interrupt
  logic [7:0] status, mask;

  acf_irq_ctrl #(.TRIG_W(TRIG_W)) u_irq (
    .clk        (clk),
    .rst_n      (rst_n),
    .tx_level   (tx_level),
    .rx_level   (rx_level),
    .tx_trig    (tx_trig),
    .rx_trig    (rx_trig),
    .tx_drop    (tx_drop),
    .rx_drop    (rx_drop),
    .tx_ovr_clr (tx_ovr_clr),
    .rx_ovr_clr (rx_ovr_clr),
    .mask_we    (mask_we),
    .mask_wdata (reg_wdata[7:0]),
    .status     (status),
    .mask       (mask),
    .irq        (irq)
  );

  // Read mux
  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      A_SMP_L:    reg_rdata[SAMPLE_W-1:0] = rx_empty ? '0 : rx_head[PAIR_W-1:SAMPLE_W];
      A_SMP_R:    reg_rdata[SAMPLE_W-1:0] = rx_empty ? '0 : rx_head[SAMPLE_W-1:0];
      A_TX_TRIG:  reg_rdata[TRIG_W-1:0]   = tx_trig;
      A_RX_TRIG:  reg_rdata[TRIG_W-1:0]   = rx_trig;
      A_STATUS:   reg_rdata[7:0]          = status;
      A_MASK:     reg_rdata[7:0]          = mask;
      A_TX_OVCLR: reg_rdata[0]            = status[BIT_TX_OVR];
      A_RX_OVCLR: reg_rdata[0]            = status[BIT_RX_OVR];
      default:    reg_rdata               = '0;
    endcase
  end

endmodule

// File: rtl/acf_checker.sv
module acf_checker #(
  parameter int LVL_W = 4,
  parameter int DEPTH = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic [LVL_W-1:0] tx_level,
  input logic [LVL_W-1:0] rx_level,
  input logic             tx_drop,
  input logic             rx_drop,
  input logic             tx_flush,
  input logic             rx_flush,
  input logic             tx_ovr_clr,
  input logic             rx_ovr_clr,
  input logic [7:0]       status,
  input logic             tx_valid
);

  localparam logic [LVL_W-1:0] DEPTH_L = LVL_W'(DEPTH);

  AST_TX_VALID_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_level == '0) |-> !tx_valid); // R2
  AST_TX_DROP_SETS_OVR: assert property (@(posedge clk) disable iff (!rst_n)
    tx_drop |=> status[5]); // R6
  AST_TX_LEVEL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    tx_level <= DEPTH_L); // R6
  AST_RX_DROP_SETS_OVR: assert property (@(posedge clk) disable iff (!rst_n)
    rx_drop |=> status[1]); // R7
  AST_RX_LEVEL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    rx_level <= DEPTH_L); // R7
  AST_TX_OVR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (status[5] && !tx_ovr_clr) |=> status[5]); // R8
  AST_RX_OVR_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_ovr_clr && !rx_drop) |=> !status[1]); // R8
  AST_TX_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    tx_flush |=> (tx_level == '0)); // R9
  AST_RX_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    rx_flush |=> (rx_level == '0)); // R9

endmodule

bind audio_chan_fifo acf_checker #(.LVL_W(LVL_W), .DEPTH(DEPTH)) u_acf_checker (
  .clk        (clk),
  .rst_n      (rst_n),
  .tx_level   (tx_level),
  .rx_level   (rx_level),
  .tx_drop    (tx_drop),
  .rx_drop    (rx_drop),
  .tx_flush   (tx_flush),
  .rx_flush   (rx_flush),
  .tx_ovr_clr (tx_ovr_clr),
  .rx_ovr_clr (rx_ovr_clr),
  .status     (status),
  .tx_valid   (tx_valid)
);

// File: tb/audio_chan_fifo_bench.sv
`timescale 1ns/1ps
module audio_chan_fifo_bench;

  localparam int DEPTH = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  reg_addr = '0;
  logic        reg_wr = 1'b0, reg_rd = 1'b0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic        tx_valid, tx_ready = 1'b0;
  logic [15:0] tx_left, tx_right;
  logic        rx_valid = 1'b0;
  logic [15:0] rx_left = '0, rx_right = '0;
  logic        irq;

  int n_chk = 0, n_fail = 0;
  logic done = 1'b0;

  always #5 clk = ~clk;

  audio_chan_fifo u_audio_chan_fifo (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rd(reg_rd), .reg_rdata(reg_rdata),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_left(tx_left),
    .tx_right(tx_right), .rx_valid(rx_valid), .rx_left(rx_left),
    .rx_right(rx_right), .irq(irq)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    reg_addr = a; reg_rd = 1'b1;
    #1 d = reg_rdata;
    @(negedge clk);
    reg_rd = 1'b0;
  endtask

  task automatic tx_pair(input logic [15:0] l, input logic [15:0] r);
    wr(4'd0, {16'h0, l});
    wr(4'd1, {16'h0, r});
  endtask

  task automatic rx_beat(input logic [15:0] l, input logic [15:0] r);
    rx_valid = 1'b1; rx_left = l; rx_right = r;
    @(negedge clk);
    rx_valid = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog all-requirements actual=hung expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    logic [7:0]  mv;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset values
    rd(4'd5, d); chk("R1 mask reset", d, 32'h33);
    rd(4'd2, d); chk("R1 tx trig reset", d, DEPTH/2 - 1);
    rd(4'd3, d); chk("R1 rx trig reset", d, DEPTH/2 - 1);
    rd(4'd4, d); chk("R1 status reset", d, 32'h10);
    #1 chk("R10 irq masked after reset", {31'h0, irq}, 0);
    chk("R2 tx_valid empty after reset", {31'h0, tx_valid}, 0);

    // R4 / R6 / R8: transmit trigger sweep over all levels
    for (int t = 0; t < DEPTH; t++) begin
      wr(4'd2, t);
      wr(4'd6, 1);
      for (int k = 0; k <= DEPTH; k++) begin
        rd(4'd4, d);
        chk($sformatf("R4 tx low trig=%0d lvl=%0d", t, k), {31'h0, d[4]}, (k <= t) ? 1 : 0);
        if (k < DEPTH) tx_pair(16'(k), 16'(t * 16 + k));
      end
      tx_pair(16'hAAAA, 16'h5555);
      rd(4'd4, d); chk("R6 tx overrun set", {31'h0, d[5]}, 1);
      rd(4'd8, d); chk("R8 tx clear read returns flag", d, 1);
      rd(4'd8, d); chk("R8 tx flag cleared", d, 0);
    end

    // R2 / R6 drain order, dropped pair absent
    tx_ready = 1'b1;
    for (int i = 0; i < DEPTH; i++) begin
      #1;
      chk("R2 tx_valid while draining", {31'h0, tx_valid}, 1);
      chk("R2 tx left order", {16'h0, tx_left}, i);
      chk("R6 tx right order", {16'h0, tx_right}, (DEPTH - 1) * 16 + i);
      @(negedge clk);
    end
    tx_ready = 1'b0;
    #1 chk("R6 dropped pair not stored", {31'h0, tx_valid}, 0);
    @(negedge clk);

    // R5 / R7: receive trigger sweep
    for (int t = 0; t < DEPTH; t++) begin
      wr(4'd3, t);
      wr(4'd7, 1);
      for (int k = 0; k <= DEPTH; k++) begin
        rd(4'd4, d);
        chk($sformatf("R5 rx avail trig=%0d lvl=%0d", t, k), {31'h0, d[0]}, (k >= t + 1) ? 1 : 0);
        if (k < DEPTH) rx_beat(16'(16'h100 + k), 16'(t));
      end
      rx_beat(16'hDEAD, 16'hBEEF);
      rd(4'd4, d); chk("R7 rx overrun set", {31'h0, d[1]}, 1);
      rd(4'd9, d); chk("R8 rx clear read returns flag", d, 1);
    end

    // R3 read order
    for (int i = 0; i < DEPTH; i++) begin
      rd(4'd0, d); chk("R3 rx left order", d, 32'h100 + i);
      rd(4'd1, d); chk("R3 rx right", d, DEPTH - 1);
    end
    rd(4'd4, d); chk("R3 rx empty after reads", {31'h0, d[0]}, 0);

    // R9 flush with bit0 clear ignored; flush beats same-cycle push
    wr(4'd3, 0);
    rx_beat(16'h1, 16'h2);
    wr(4'd7, 2);
    rd(4'd4, d); chk("R9 flush bit0 clear ignored", {31'h0, d[0]}, 1);
    rx_valid = 1'b1; rx_left = 16'h7; rx_right = 16'h8;
    wr(4'd7, 1);
    rx_valid = 1'b0;
    rd(4'd4, d); chk("R9 flush wins over push", d[1:0], 0);

    // Set all four status bits
    wr(4'd2, 3);
    for (int k = 0; k <= DEPTH; k++) tx_pair(16'(k), 16'(k));
    wr(4'd6, 1);
    for (int k = 0; k <= DEPTH; k++) rx_beat(16'(k), 16'(k));
    rd(4'd4, d); chk("R9 flush keeps tx overrun", d, 32'h33);

    // R10 mask sweep
    for (int m = 0; m < 16; m++) begin
      mv = {2'b00, m[3:2], 2'b00, m[1:0]};
      wr(4'd5, {24'h0, mv});
      #1 chk($sformatf("R10 irq mask=%02h", mv), {31'h0, irq}, (m != 15) ? 1 : 0);
      rd(4'd5, d); chk("R10 mask readback", d, {24'h0, mv});
    end

    // R8 clear independence
    rd(4'd8, d); chk("R8 tx clear", d, 1);
    rd(4'd4, d); chk("R8 rx flag kept", d, 32'h13);
    rd(4'd9, d); chk("R8 rx clear", d, 1);
    rd(4'd4, d); chk("R8 both cleared", d, 32'h11);
    wr(4'd7, 1);
    wr(4'd5, 32'h23);
    #1 chk("R10 tx low unmasked", {31'h0, irq}, 1);
    wr(4'd5, 32'h10);
    #1 chk("R10 tx low masked", {31'h0, irq}, 0);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule